// File: doc/BRIEF.md
# Shared-Prescaler Timer Tick Generator

This block turns one peripheral clock into five independent count-enable strobes, one per timer channel. Two 8-bit prescalers form the first stage. The first feeds channels 0 and 1, the second feeds channels 2, 3 and 4. Behind its group's prescaler, each channel has a power-of-two divider of its own. A source selector on each channel can route a synchronized external tick input to the channel instead of the divided prescaler output. Each output is a single-cycle strobe that a downstream timer counter uses as its count enable. The block does not generate a derived clock.

Software programs the block through a small write port with two words. Word 0 holds both prescaler values. Word 1 holds one 4-bit selector/divider field per channel. Any write restarts every internal counter. Because of this, the phase of every periodic output is fixed by the last write, and no partial period left over from the old settings can appear.

Top module: `tmr_tick_tree`

## Requirements
- R1: While rst_n is low every ch_tick bit is 0. Reset leaves both prescaler values at 0 and every channel field at 0, so after reset each channel strobes every 2 cycles.
- R2: A prescaler value P makes the prescaler emit one tick every P+1 clock cycles. A channel in divider mode with ratio D therefore strobes once every D*(P+1) cycles.
- R3: A channel field value k in 0..3 selects a divider ratio of 2^(k+1), which is 2, 4, 8 or 16.
- R4: Field values 5 to 15 behave exactly like ratio 16.
- R5: Field value 4 selects the group's external input. Each external input is passed through a two-flop synchronizer. A low-to-high change on the input produces exactly one strobe, on the third rising clock edge after the change. A held level or a falling change produces no strobe.
- R6: Prescaler 0 and external input 0 (ext_in[0]) serve channels 0 and 1. Prescaler 1 and external input 1 (ext_in[1]) serve channels 2, 3 and 4.
- R7: A write with wr_addr=0 loads prescaler 0 from wr_data[7:0] and prescaler 1 from wr_data[15:8]. A write with wr_addr=1 loads channel c's field from wr_data[4c+3:4c].
- R8: Any write restarts all prescaler and divider counters and clears every ch_tick bit in the following cycle. A divider-mode channel then gives its first strobe exactly D*(P+1) clock edges after the write edge, and repeats with that period.
- R9: No ch_tick bit is ever high in two consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Peripheral clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Configuration write strobe |
| wr_addr | input | 1 | Word select: 0 = prescaler word, 1 = channel field word |
| wr_data | input | 32 | Configuration write data |
| ext_in | input | 2 | Asynchronous external tick inputs, one per channel group |
| ch_tick | output | 5 | Single-cycle count-enable strobe per channel |

## Verification
Every result has a fixed cycle position measured from the edge that samples a write or the release of reset. A divider-mode strobe is due on edge number D*(P+1) and on each multiple of it. An external strobe is due on the third edge after the input rises. All outputs must read 0 on the first edge after a write. The bench starts counting edges at the write edge and samples at the falling edge after each rising edge. For every cycle of a 64-cycle window it compares each channel against the strobe pattern it predicts, so both early and late strobes are caught. The checker adds cycle-level relations: each strobe must be traced to a prescaler tick or an external edge in the previous cycle.

// File: rtl/tick_pkg.sv
package tick_pkg;
    // Channel field code that routes the external input to the channel.
    localparam int SEL_EXT_CODE  = 4;
    // Number of power-of-two divider codes (ratios 2..16).
    localparam int NUM_DIV_CODES = 4;

    typedef enum logic {
        ADDR_PRESC = 1'b0,
        ADDR_FIELD = 1'b1
    } cfg_addr_e;
endpackage

// File: rtl/tick_prescaler.sv
module tick_prescaler #(
    parameter int PS_W = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            restart,
    input  logic [PS_W-1:0] limit,
    output logic            tick
);
    typedef struct packed {
        logic [PS_W-1:0] cnt;
    } ps_state_t;

    ps_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        tick = (st_q.cnt == limit);
        if (restart || tick) begin
            st_d.cnt = '0;
        end else begin
            st_d.cnt = st_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end
endmodule

// File: rtl/tick_edge_sync.sv
module tick_edge_sync (
    input  logic clk,
    input  logic rst_n,
    input  logic pin,
    output logic pulse
);
    typedef struct packed {
        logic meta;
        logic sync;
        logic prev;
    } sy_state_t;

    sy_state_t st_d, st_q;

    always_comb begin
        st_d.meta = pin;
        st_d.sync = st_q.meta;
        st_d.prev = st_q.sync;
        pulse     = st_q.sync & ~st_q.prev;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end
endmodule

// File: rtl/tick_divider.sv
module tick_divider
    import tick_pkg::*;
#(
    parameter int FIELD_W = 4,
    parameter int CNT_W   = NUM_DIV_CODES
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               restart,
    input  logic               pre_tick,
    input  logic               ext_tick,
    input  logic [FIELD_W-1:0] field,
    output logic               tick
);
    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             out;
    } dv_state_t;

    dv_state_t        st_d, st_q;
    logic             use_ext;
    logic             hit;
    logic [CNT_W-1:0] lim;
    int unsigned      lg;

    always_comb begin
        st_d    = st_q;
        use_ext = (field == FIELD_W'(SEL_EXT_CODE));
        if (int'(field) >= NUM_DIV_CODES) lg = NUM_DIV_CODES - 1;
        else                              lg = int'(field);
        lim = CNT_W'((32'd1 << (lg + 1)) - 32'd1);
        hit = pre_tick && (st_q.cnt == lim);

        if (restart) begin
            st_d.out = 1'b0;
        end else if (use_ext) begin
            st_d.out = ext_tick;
        end else begin
            st_d.out = hit;
        end

        if (restart || use_ext) begin
            st_d.cnt = '0;
        end else if (pre_tick) begin
            st_d.cnt = hit ? '0 : st_q.cnt + 1'b1;
        end
    end

    assign tick = st_q.out;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end
endmodule

// File: rtl/tmr_tick_tree.sv
module tmr_tick_tree
    import tick_pkg::*;
#(
    parameter int DATA_W  = 32,
    parameter int PS_W    = 8,
    parameter int FIELD_W = 4,
    parameter int NUM_CH  = 5,
    parameter int GRP0_CH = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [1:0]        ext_in,
    output logic [NUM_CH-1:0] ch_tick
);
    localparam int NUM_GRP = 2;
    localparam int FLD_TOT = NUM_CH * FIELD_W;

    typedef struct packed {
        logic [NUM_GRP-1:0][PS_W-1:0]   presc;
        logic [NUM_CH-1:0][FIELD_W-1:0] field;
    } cfg_t;

    cfg_t                 cfg_d, cfg_q;
    logic [NUM_GRP-1:0]   pre_tick;
    logic [NUM_GRP-1:0]   ext_tick;
    logic [FLD_TOT-1:0]   field_flat;

    always_comb begin
        cfg_d = cfg_q;
        if (wr_en && (cfg_addr_e'(wr_addr) == ADDR_PRESC)) begin
            for (int g = 0; g < NUM_GRP; g++) begin
                cfg_d.presc[g] = wr_data[g*PS_W +: PS_W];
            end
        end
        if (wr_en && (cfg_addr_e'(wr_addr) == ADDR_FIELD)) begin
            for (int c = 0; c < NUM_CH; c++) begin
                cfg_d.field[c] = wr_data[c*FIELD_W +: FIELD_W];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cfg_q <= '0;
        else        cfg_q <= cfg_d;
    end

    assign field_flat = cfg_q.field;

    generate
        if (DATA_W > FLD_TOT) begin : g_spare
            logic unused_hi;
            assign unused_hi = ^wr_data[DATA_W-1:FLD_TOT];
        end

        for (genvar g = 0; g < NUM_GRP; g++) begin : g_grp
            tick_prescaler #(.PS_W(PS_W)) u_ps (
                .clk     (clk),
                .rst_n   (rst_n),
                .restart (wr_en),
                .limit   (cfg_q.presc[g]),
                .tick    (pre_tick[g])
            );
            tick_edge_sync u_sync (
                .clk   (clk),
                .rst_n (rst_n),
                .pin   (ext_in[g]),
                .pulse (ext_tick[g])
            );
        end

        for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
            localparam int GRP = (c < GRP0_CH) ? 0 : 1;
            tick_divider #(.FIELD_W(FIELD_W)) u_div (
                .clk      (clk),
                .rst_n    (rst_n),
                .restart  (wr_en),
                .pre_tick (pre_tick[GRP]),
                .ext_tick (ext_tick[GRP]),
                .field    (cfg_q.field[c]),
                .tick     (ch_tick[c])
            );
        end
    endgenerate
endmodule

// File: rtl/tick_tree_chk.sv
module tick_tree_chk #(
    parameter int FIELD_W = 4,
    parameter int NUM_CH  = 5,
    parameter int GRP0_CH = 2
) (
    input logic                       clk,
    input logic                       rst_n,
    input logic                       wr_en,
    input logic [NUM_CH-1:0]          ch_tick,
    input logic [1:0]                 pre_tick,
    input logic [1:0]                 ext_tick,
    input logic [NUM_CH*FIELD_W-1:0]  field_flat
);
    localparam logic [FIELD_W-1:0] EXT_CODE = FIELD_W'(4);

    // R1: outputs silent while reset is held
    always @(posedge clk) begin
        if (!rst_n) begin
            p_reset_quiet_r1: assert (ch_tick == '0)
                else $error("p_reset_quiet_r1");
        end
    end

    // R8: a write clears every strobe in the next cycle
    p_write_clears_r8: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> (ch_tick == '0));

    generate
        for (genvar c = 0; c < NUM_CH; c++) begin : g_c
            localparam int G = (c < GRP0_CH) ? 0 : 1;

            // R9: strobes last exactly one cycle
            p_single_cycle_r9: assert property (@(posedge clk) disable iff (!rst_n)
                ch_tick[c] |=> !ch_tick[c]);

            // R6 / R2: a divider-mode strobe follows a tick of its own group's prescaler
            p_group_presc_r6: assert property (@(posedge clk) disable iff (!rst_n)
                (ch_tick[c] && ($past(field_flat[c*FIELD_W +: FIELD_W]) != EXT_CODE))
                |-> $past(pre_tick[G]));

            // R5: an external-mode strobe follows an edge on its own group's input
            p_ext_source_r5: assert property (@(posedge clk) disable iff (!rst_n)
                (ch_tick[c] && ($past(field_flat[c*FIELD_W +: FIELD_W]) == EXT_CODE))
                |-> $past(ext_tick[G]));
        end
    endgenerate
endmodule

bind tmr_tick_tree tick_tree_chk #(
    .FIELD_W (FIELD_W),
    .NUM_CH  (NUM_CH),
    .GRP0_CH (GRP0_CH)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_en      (wr_en),
    .ch_tick    (ch_tick),
    .pre_tick   (pre_tick),
    .ext_tick   (ext_tick),
    .field_flat (field_flat)
);

// File: tb/sim_tmr_tick_tree.sv
`timescale 1ns/100ps
module sim_tmr_tick_tree;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic        wr_addr = 1'b0;
    logic [31:0] wr_data = '0;
    logic [1:0]  ext_in = '0;
    logic [4:0]  ch_tick;

    int n_checks = 0;
    int n_fails  = 0;

    always #2.5 clk = ~clk;

    tmr_tick_tree u0 (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .ext_in  (ext_in),
        .ch_tick (ch_tick)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input int got, input int exp);
        n_checks++;
        if (!ok) begin
            n_fails++;
            $display("FAIL %s %s: got %0d expected %0d", req, what, got, exp);
        end
    endtask

    // One write; returns just after the sampling edge's following falling edge.
    task automatic cfg_write(input bit addr, input logic [31:0] data);
        @(negedge clk);
        wr_en   = 1'b1;
        wr_addr = addr;
        wr_data = data;
        @(posedge clk);
        @(negedge clk);
        wr_en   = 1'b0;
        wr_data = '0;
    endtask

    // Checks 64 cycles of strobes: channel c must tick on edge j iff j % per[c] == 0
    // (per[c] == 0 means never). Edge 1 is the first edge after the reference edge.
    task automatic watch(input int p0, input int p1, input int p2, input int p3,
                         input int p4, input string req);
        int per[5];
        int bad[5];
        int first_j[5];
        int first_got[5];
        per = '{p0, p1, p2, p3, p4};
        for (int c = 0; c < 5; c++) begin
            bad[c] = 0; first_j[c] = 0; first_got[c] = 0;
        end
        for (int j = 1; j <= 64; j++) begin
            @(posedge clk);
            @(negedge clk);
            for (int c = 0; c < 5; c++) begin
                bit want;
                want = (per[c] != 0) && ((j % per[c]) == 0);
                if (ch_tick[c] != want) begin
                    if (bad[c] == 0) begin
                        first_j[c]   = j;
                        first_got[c] = ch_tick[c];
                    end
                    bad[c]++;
                end
            end
        end
        for (int c = 0; c < 5; c++) begin
            check(bad[c] == 0, req,
                  $sformatf("ch%0d period %0d tick at edge %0d", c, per[c], first_j[c]),
                  first_got[c], first_got[c] ^ 1);
        end
    endtask

    task automatic t_reset();
        // R1: quiet during reset
        for (int i = 0; i < 4; i++) begin
            @(negedge clk);
            check(ch_tick == 5'b0, "R1", "ch_tick during reset", ch_tick, 0);
        end
        rst_n = 1'b1;
        // R1: default config -> every channel period 2
        watch(2, 2, 2, 2, 2, "R1");
    endtask

    task automatic t_prescale();
        // R2/R6/R7: P0=3 (byte 0), P1=2 (byte 1), all ratios 2
        cfg_write(1'b0, 32'h0000_0203);
        cfg_write(1'b1, 32'h0000_0000);
        watch(8, 8, 6, 6, 6, "R2");
    endtask

    task automatic t_ratios();
        // R3/R7: P0=0, P1=1; fields ch0=1,ch1=3,ch2=0,ch3=2,ch4=3
        cfg_write(1'b0, 32'h0000_0100);
        cfg_write(1'b1, 32'h0003_2031);
        watch(4, 16, 4, 16, 32, "R3");
    endtask

    task automatic t_big_codes();
        // R4: codes 5,15,9 act as 16; code 3 is 16; code 0 is 2
        cfg_write(1'b0, 32'h0000_0000);
        cfg_write(1'b1, 32'h0000_39F5);
        watch(16, 16, 16, 16, 2, "R4");
    endtask

    task automatic t_restart();
        // R8: rewrite mid-period; phase restarts from the new write edge
        cfg_write(1'b0, 32'h0000_0203);
        cfg_write(1'b1, 32'h0000_0000);
        repeat (5) @(negedge clk);
        cfg_write(1'b0, 32'h0000_0203);
        watch(8, 8, 6, 6, 6, "R8");
    endtask

    // Samples n edges after driving ext_in[grp] to lvl; expects a tick on ch_on
    // at edge 3 only when rise=1, never on ch_off.
    task automatic ext_step(input int grp, input bit lvl, input bit rise,
                            input int ch_on, input int ch_off, input string req);
        @(negedge clk);
        ext_in[grp] = lvl;
        for (int j = 1; j <= 6; j++) begin
            bit want;
            @(posedge clk);
            @(negedge clk);
            want = rise && (j == 3);
            check(ch_tick[ch_on] == want, req,
                  $sformatf("ext%0d ch%0d tick at edge %0d", grp, ch_on, j),
                  ch_tick[ch_on], want);
            check(ch_tick[ch_off] == 1'b0, "R6",
                  $sformatf("other group ch%0d at edge %0d", ch_off, j),
                  ch_tick[ch_off], 0);
        end
    endtask

    task automatic t_external();
        // R5/R6: field 4 on ch1 and ch3
        cfg_write(1'b0, 32'h0000_0000);
        cfg_write(1'b1, 32'h0000_4040);
        ext_step(0, 1'b1, 1'b1, 1, 3, "R5");
        ext_step(0, 1'b1, 1'b0, 1, 3, "R5");   // held high: no tick
        ext_step(0, 1'b0, 1'b0, 1, 3, "R5");   // falling: no tick
        ext_step(1, 1'b1, 1'b1, 3, 1, "R5");
        ext_step(1, 1'b0, 1'b0, 3, 1, "R5");
    endtask

    initial begin
        #(200000 * 5);
        n_fails++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end

    initial begin
        t_reset();
        t_prescale();
        t_ratios();
        t_big_codes();
        t_restart();
        t_external();
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end
endmodule